// File: doc/BRIEF.md
# Serial Channel Register Front End

This block is the register front end of one asynchronous serial channel inside a dual-channel UART. A host reaches it over a plain byte-wide bus with a select, a read strobe, a write strobe and a small register index. The block holds the channel's two mode registers, the command decoder, the status flags, the received-character buffer and the outgoing character. It also tracks whether the receiver and the transmitter are switched on.

The line side is reduced to strobes. A line receiver offers each received character with a one-cycle strobe. A line transmitter reports the end of a character with a one-cycle done pulse and is told to start with a registered start pulse and a data byte. Both data paths are trimmed to the character length held in the first mode register. An echo mode in the second mode register sends every accepted character straight back out and cuts the host off from the transmit path. Baud timing, bit shifting and interrupt merging sit in neighbouring blocks.

Top module: `sio_chan_regs`

## Requirements
- R1: A synchronous reset clears every status flag, turns off the receiver and the transmitter, returns the mode pointer to the first mode register, loads both mode registers with their reset values (0x03 and 0x00 by default) and keeps `tx_start` low.
- R2: The status byte carries receiver-ready at bit 0, holding-buffer-full at bit 1, transmitter-ready at bit 2 and transmitter-empty at bit 3. Bits 7:4 read zero at all times, including after a miscellaneous command code 4 (clear errors).
- R3: The mode index reaches the first mode register on the first access after reset or after miscellaneous command code 1. Every later read or write reaches the second mode register.
- R4: Command bits 6:4 set to code 2 turn the receiver off and clear status bits 0 and 1. Code 3 turns the transmitter off and clears status bits 2 and 3.
- R5: Command bits 3:2 set to 1 turn the transmitter on and set status bits 2 and 3. Set to 2, they turn it off and clear those bits.
- R6: Command bits 1:0 set to 1 turn the receiver on and clear status bits 0 and 1. Set to 2, they turn it off and leave the receive flags as they were.
- R7: The three command fields of one write all take effect in the same cycle. They are applied in this order: bits 6:4, then bits 3:2, then bits 1:0. So a later field overrides an earlier one.
- R8: A receive strobe is accepted only while the receiver is on and status bit 1 is clear. An accepted character is stored trimmed to the character length, and status bits 0 and 1 are set. Any other strobe changes nothing.
- R9: A read of the data index returns the stored received character and clears status bits 0 and 1, unless a new character is accepted in the same cycle.
- R10: Outside echo mode, a write of the data index clears status bits 2 and 3. If the transmitter is on, the next cycle shows `tx_start` high for one cycle with the trimmed byte on `tx_byte`. A `tx_done` pulse while the transmitter is on sets bits 2 and 3 again.
- R11: Mode register 1 bits 1:0 equal to 0, 1, 2 or 3 select 5, 6, 7 or 8 data bits. The unused high bits are forced to zero on both the receive and the transmit path.
- R12: With mode register 2 bits 7:6 equal to 01, every accepted character appears on `tx_byte` with `tx_start` high in the next cycle, whether or not the transmitter is on. In this mode a host write to the data index starts nothing and leaves status bits 2 and 3 unchanged.
- R13: The index map is 0 for the mode registers, 1 for status (read only), 2 for command (write only) and 3 for data. A read of the command index or of any unmapped index returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Host access select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_idx | input | IDX_W | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is selected |
| rx_strobe | input | 1 | Character offered by the line receiver |
| rx_byte | input | 8 | Received character |
| tx_done | input | 1 | Line transmitter finished a character |
| tx_start | output | 1 | One-cycle request to send `tx_byte` |
| tx_byte | output | 8 | Character to send, trimmed to length |
| rx_enabled | output | 1 | Receiver is on |
| tx_enabled | output | 1 | Transmitter is on |

## Verification
The bench builds the block with a three-bit index and echo support compiled in. The wider index puts four unmapped register slots within reach, so the bench can show that they read back as zero. The echo variant lets the bench drive the loop-back path and the blocked host transmit path, and it can step through all four character lengths on live data.

// File: rtl/sio_chan_pkg.sv
package sio_chan_pkg;

   typedef enum logic {
      PTR_MR1 = 1'b0,
      PTR_MR2 = 1'b1
   } mr_ptr_e;

   typedef struct packed {
      logic ptr_reset;
      logic rx_reset;
      logic tx_reset;
      logic err_clr;
      logic tx_on;
      logic tx_off;
      logic rx_on;
      logic rx_off;
   } cmd_act_t;

   localparam logic [2:0] MISC_PTR_RST = 3'd1;
   localparam logic [2:0] MISC_RX_RST  = 3'd2;
   localparam logic [2:0] MISC_TX_RST  = 3'd3;
   localparam logic [2:0] MISC_ERR_CLR = 3'd4;
   localparam logic [1:0] EN_ON        = 2'd1;
   localparam logic [1:0] EN_OFF       = 2'd2;
   localparam logic [1:0] MODE_ECHO    = 2'b01;

   // Keep the low 5..8 bits selected by a 2-bit length code
   function automatic logic [7:0] len_mask(input logic [1:0] len);
      return 8'hFF >> (2'd3 - len);
   endfunction

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
   import sio_chan_pkg::*;
(
   input  logic       cmd_wr,
   input  logic [7:0] cmd_byte,
   output cmd_act_t   act
);
   logic [2:0] misc_f;
   logic [1:0] tx_f;
   logic [1:0] rx_f;

   assign misc_f = cmd_byte[6:4];
   assign tx_f   = cmd_byte[3:2];
   assign rx_f   = cmd_byte[1:0];

   always_comb begin
      act           = '0;
      act.ptr_reset = cmd_wr && (misc_f == MISC_PTR_RST);
      act.rx_reset  = cmd_wr && (misc_f == MISC_RX_RST);
      act.tx_reset  = cmd_wr && (misc_f == MISC_TX_RST);
      act.err_clr   = cmd_wr && (misc_f == MISC_ERR_CLR);
      act.tx_on     = cmd_wr && (tx_f == EN_ON);
      act.tx_off    = cmd_wr && (tx_f == EN_OFF);
      act.rx_on     = cmd_wr && (rx_f == EN_ON);
      act.rx_off    = cmd_wr && (rx_f == EN_OFF);
   end
endmodule

// File: rtl/sio_mode_regs.sv
module sio_mode_regs
   import sio_chan_pkg::*;
#(
   parameter logic [7:0] MR1_RST = 8'h03,
   parameter logic [7:0] MR2_RST = 8'h00
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       acc,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       ptr_reset,
   output logic [7:0] mr1,
   output logic [7:0] mr2,
   output logic [7:0] rd_val
);
   mr_ptr_e ptr;

   assign rd_val = (ptr == PTR_MR1) ? mr1 : mr2;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr <= PTR_MR1;
         mr1 <= MR1_RST;
         mr2 <= MR2_RST;
      end else if (ptr_reset) begin
         ptr <= PTR_MR1;
      end else if (acc) begin
         if (wr) begin
            if (ptr == PTR_MR1) mr1 <= wdata;
            else                mr2 <= wdata;
         end
         ptr <= PTR_MR2;
      end
   end
endmodule

// File: rtl/sio_flags.sv
module sio_flags
   import sio_chan_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  cmd_act_t act,
   input  logic     rx_accept,
   input  logic     rx_read,
   input  logic     tx_wr_clear,
   input  logic     tx_done,
   output logic     rx_en,
   output logic     tx_en,
   output logic     rx_rdy,
   output logic     rx_full,
   output logic     tx_rdy,
   output logic     tx_emt
);
   logic n_rx_en, n_tx_en, n_rx_rdy, n_rx_full, n_tx_rdy, n_tx_emt;

   // Events first, then the command fields in their fixed order
   always_comb begin
      n_rx_en   = rx_en;
      n_tx_en   = tx_en;
      n_rx_rdy  = rx_rdy;
      n_rx_full = rx_full;
      n_tx_rdy  = tx_rdy;
      n_tx_emt  = tx_emt;
      if (tx_done && tx_en) begin
         n_tx_rdy = 1'b1;
         n_tx_emt = 1'b1;
      end
      if (rx_accept) begin
         n_rx_rdy  = 1'b1;
         n_rx_full = 1'b1;
      end else if (rx_read) begin
         n_rx_rdy  = 1'b0;
         n_rx_full = 1'b0;
      end
      if (tx_wr_clear) begin
         n_tx_rdy = 1'b0;
         n_tx_emt = 1'b0;
      end
      if (act.rx_reset) begin
         n_rx_en   = 1'b0;
         n_rx_rdy  = 1'b0;
         n_rx_full = 1'b0;
      end
      if (act.tx_reset) begin
         n_tx_en  = 1'b0;
         n_tx_rdy = 1'b0;
         n_tx_emt = 1'b0;
      end
      if (act.tx_on) begin
         n_tx_en  = 1'b1;
         n_tx_rdy = 1'b1;
         n_tx_emt = 1'b1;
      end else if (act.tx_off) begin
         n_tx_en  = 1'b0;
         n_tx_rdy = 1'b0;
         n_tx_emt = 1'b0;
      end
      if (act.rx_on) begin
         n_rx_en   = 1'b1;
         n_rx_rdy  = 1'b0;
         n_rx_full = 1'b0;
      end else if (act.rx_off) begin
         n_rx_en = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_en   <= 1'b0;
         tx_en   <= 1'b0;
         rx_rdy  <= 1'b0;
         rx_full <= 1'b0;
         tx_rdy  <= 1'b0;
         tx_emt  <= 1'b0;
      end else begin
         rx_en   <= n_rx_en;
         tx_en   <= n_tx_en;
         rx_rdy  <= n_rx_rdy;
         rx_full <= n_rx_full;
         tx_rdy  <= n_tx_rdy;
         tx_emt  <= n_tx_emt;
      end
   end
endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
   import sio_chan_pkg::*;
#(
   parameter int         IDX_W    = 3,
   parameter int         MODE_IDX = 0,
   parameter int         STAT_IDX = 1,
   parameter int         CMD_IDX  = 2,
   parameter int         DATA_IDX = 3,
   parameter logic [7:0] MR1_RST  = 8'h03,
   parameter logic [7:0] MR2_RST  = 8'h00,
   parameter bit         ECHO_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_sel,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [IDX_W-1:0] bus_idx,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             rx_strobe,
   input  logic [7:0]       rx_byte,
   input  logic             tx_done,
   output logic             tx_start,
   output logic [7:0]       tx_byte,
   output logic             rx_enabled,
   output logic             tx_enabled
);
   localparam int         NUM_SLOTS = 1 << IDX_W;
   localparam logic [IDX_W-1:0] I_MODE = IDX_W'(MODE_IDX);
   localparam logic [IDX_W-1:0] I_STAT = IDX_W'(STAT_IDX);
   localparam logic [IDX_W-1:0] I_CMD  = IDX_W'(CMD_IDX);
   localparam logic [IDX_W-1:0] I_DATA = IDX_W'(DATA_IDX);

   generate
      if (IDX_W < 2)
         $error("sio_chan_regs: IDX_W must be at least 2");
      if (MODE_IDX >= NUM_SLOTS || STAT_IDX >= NUM_SLOTS ||
          CMD_IDX >= NUM_SLOTS || DATA_IDX >= NUM_SLOTS)
         $error("sio_chan_regs: register index outside index range");
      if (MODE_IDX == STAT_IDX || MODE_IDX == CMD_IDX || MODE_IDX == DATA_IDX ||
          STAT_IDX == CMD_IDX || STAT_IDX == DATA_IDX || CMD_IDX == DATA_IDX)
         $error("sio_chan_regs: register indices must differ");
   endgenerate

   logic       bus_acc, mode_acc, cmd_wr, data_wr, rx_read;
   logic       rx_accept, tx_wr_clear, echo_on;
   logic       rx_rdy, rx_full, tx_rdy, tx_emt;
   logic [7:0] mr1, mr2, mode_rd, stat_byte, char_mask;
   logic [7:0] rx_buf, tx_hold;
   logic       tx_start_q;
   cmd_act_t   act;

   assign bus_acc  = bus_sel && (bus_rd || bus_wr);
   assign mode_acc = bus_acc && (bus_idx == I_MODE);
   assign cmd_wr   = bus_sel && bus_wr && (bus_idx == I_CMD);
   assign data_wr  = bus_sel && bus_wr && (bus_idx == I_DATA);
   assign rx_read  = bus_sel && bus_rd && (bus_idx == I_DATA);

   sio_cmd_decode u_dec (
      .cmd_wr   (cmd_wr),
      .cmd_byte (bus_wdata),
      .act      (act)
   );

   sio_mode_regs #(
      .MR1_RST (MR1_RST),
      .MR2_RST (MR2_RST)
   ) u_mode (
      .clk       (clk),
      .rst       (rst),
      .acc       (mode_acc),
      .wr        (bus_wr),
      .wdata     (bus_wdata),
      .ptr_reset (act.ptr_reset),
      .mr1       (mr1),
      .mr2       (mr2),
      .rd_val    (mode_rd)
   );

   generate
      if (ECHO_EN) begin : g_echo
         assign echo_on = (mr2[7:6] == MODE_ECHO);
      end else begin : g_no_echo
         assign echo_on = 1'b0;
      end
   endgenerate

   assign char_mask   = len_mask(mr1[1:0]);
   assign rx_accept   = rx_strobe && rx_enabled && !rx_full;
   assign tx_wr_clear = data_wr && !echo_on;

   sio_flags u_flags (
      .clk         (clk),
      .rst         (rst),
      .act         (act),
      .rx_accept   (rx_accept),
      .rx_read     (rx_read),
      .tx_wr_clear (tx_wr_clear),
      .tx_done     (tx_done),
      .rx_en       (rx_enabled),
      .tx_en       (tx_enabled),
      .rx_rdy      (rx_rdy),
      .rx_full     (rx_full),
      .tx_rdy      (tx_rdy),
      .tx_emt      (tx_emt)
   );

   assign stat_byte = {4'b0000, tx_emt, tx_rdy, rx_full, rx_rdy};

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_buf     <= '0;
         tx_hold    <= '0;
         tx_start_q <= 1'b0;
      end else begin
         tx_start_q <= 1'b0;
         if (rx_accept) rx_buf <= rx_byte & char_mask;
         if (echo_on && rx_accept) begin
            tx_hold    <= rx_byte & char_mask;
            tx_start_q <= 1'b1;
         end else if (tx_wr_clear) begin
            tx_hold    <= bus_wdata & char_mask;
            tx_start_q <= tx_enabled;
         end
      end
   end

   assign tx_start = tx_start_q;
   assign tx_byte  = tx_hold;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && bus_rd) begin
         if (bus_idx == I_MODE)      bus_rdata = mode_rd;
         else if (bus_idx == I_STAT) bus_rdata = stat_byte;
         else if (bus_idx == I_DATA) bus_rdata = rx_buf;
      end
   end
endmodule

// File: rtl/sio_chan_regs_chk.sv
module sio_chan_regs_chk (
   input logic       clk,
   input logic       rst,
   input logic [7:0] status,
   input logic       rx_strobe,
   input logic       rx_read,
   input logic       cmd_wr,
   input logic       rx_enabled,
   input logic       tx_enabled,
   input logic       echo_on,
   input logic       tx_start
);
   // R2
   upper_nibble_zero_chk: assert property (@(posedge clk) disable iff (rst)
      status[7:4] == 4'h0);

   // R8
   rx_flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
      status[0] == status[1]);

   // R10
   tx_flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
      status[2] == status[3]);

   // R8
   rx_blocked_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_strobe && !rx_enabled && !cmd_wr && !status[0]) |=> !status[0]);

   // R9
   rx_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_read && !rx_strobe) |=> !status[0]);

   // R10
   tx_start_cause_chk: assert property (@(posedge clk) disable iff (rst)
      tx_start |-> ($past(tx_enabled) || $past(echo_on)));

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (status == 8'h00 && !tx_start && !rx_enabled && !tx_enabled));
endmodule

bind sio_chan_regs sio_chan_regs_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .status     (stat_byte),
   .rx_strobe  (rx_strobe),
   .rx_read    (rx_read),
   .cmd_wr     (cmd_wr),
   .rx_enabled (rx_enabled),
   .tx_enabled (tx_enabled),
   .echo_on    (echo_on),
   .tx_start   (tx_start)
);

// File: tb/test_sio_chan_regs.sv
module test_sio_chan_regs;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W      = 3;

   localparam logic [1:0] OP_RD = 2'd0;
   localparam logic [1:0] OP_WR = 2'd1;
   localparam logic [1:0] OP_RX = 2'd2;
   localparam logic [1:0] OP_DN = 2'd3;

   typedef struct packed {
      logic [1:0] op;
      logic [2:0] idx;
      logic [7:0] dat;
      logic [7:0] exp;
      logic       ct;
      logic       et;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 63;
   localparam vec_t VEC [NV] = '{
      '{OP_RD, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd1 },  // R1 status after reset
      '{OP_RD, 3'd0, 8'h00, 8'h03, 1'b0, 1'b0, 4'd3 },  // R3 first access MR1
      '{OP_RD, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd3 },  // R3 then MR2
      '{OP_WR, 3'd0, 8'h15, 8'h00, 1'b0, 1'b0, 4'd3 },
      '{OP_RD, 3'd0, 8'h00, 8'h15, 1'b0, 1'b0, 4'd3 },  // R3 write went to MR2
      '{OP_WR, 3'd2, 8'h10, 8'h00, 1'b0, 1'b0, 4'd3 },
      '{OP_WR, 3'd0, 8'h41, 8'h00, 1'b0, 1'b0, 4'd3 },
      '{OP_RD, 3'd0, 8'h00, 8'h15, 1'b0, 1'b0, 4'd3 },
      '{OP_WR, 3'd2, 8'h10, 8'h00, 1'b0, 1'b0, 4'd3 },
      '{OP_RD, 3'd0, 8'h00, 8'h41, 1'b0, 1'b0, 4'd3 },  // R3 pointer back to MR1
      '{OP_RX, 3'd0, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd8 },
      '{OP_RD, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd8 },  // R8 disabled receiver
      '{OP_WR, 3'd2, 8'h05, 8'h00, 1'b0, 1'b0, 4'd5 },
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd5 },  // R5 R6 both on
      '{OP_RX, 3'd0, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd8 },
      '{OP_RD, 3'd1, 8'h00, 8'h0F, 1'b0, 1'b0, 4'd8 },  // R8 accepted
      '{OP_RX, 3'd0, 8'h12, 8'h00, 1'b0, 1'b0, 4'd8 },
      '{OP_RD, 3'd3, 8'h00, 8'h3F, 1'b0, 1'b0, 4'd11},  // R11 six bits, R8 full kept
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd9 },  // R9 read cleared
      '{OP_WR, 3'd3, 8'hAB, 8'h2B, 1'b1, 1'b1, 4'd10},  // R10 start, six bits
      '{OP_RD, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd10},
      '{OP_DN, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd10},
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd10},  // R10 done sets flags
      '{OP_RD, 3'd5, 8'h00, 8'h00, 1'b0, 1'b0, 4'd13},  // R13 unmapped
      '{OP_RD, 3'd2, 8'h00, 8'h00, 1'b0, 1'b0, 4'd13},  // R13 command write only
      '{OP_WR, 3'd2, 8'h40, 8'h00, 1'b0, 1'b0, 4'd2 },
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd2 },  // R2 after clear errors
      '{OP_WR, 3'd2, 8'h08, 8'h00, 1'b0, 1'b0, 4'd5 },
      '{OP_WR, 3'd3, 8'h11, 8'h00, 1'b1, 1'b0, 4'd10},  // R10 no start when off
      '{OP_RD, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd5 },  // R5 disabled
      '{OP_WR, 3'd2, 8'h24, 8'h00, 1'b0, 1'b0, 4'd4 },
      '{OP_RX, 3'd0, 8'h01, 8'h00, 1'b0, 1'b0, 4'd4 },
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd4 },  // R4 rx reset, tx on
      '{OP_WR, 3'd2, 8'h35, 8'h00, 1'b0, 1'b0, 4'd7 },
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd7 },  // R7 enable overrides reset
      '{OP_RX, 3'd0, 8'h80, 8'h00, 1'b0, 1'b0, 4'd7 },
      '{OP_RD, 3'd3, 8'h00, 8'h00, 1'b0, 1'b0, 4'd11},  // R11 bit 7 dropped
      '{OP_RX, 3'd0, 8'h07, 8'h00, 1'b0, 1'b0, 4'd6 },
      '{OP_WR, 3'd2, 8'h02, 8'h00, 1'b0, 1'b0, 4'd6 },
      '{OP_RD, 3'd1, 8'h00, 8'h0F, 1'b0, 1'b0, 4'd6 },  // R6 off keeps flags
      '{OP_RD, 3'd3, 8'h00, 8'h07, 1'b0, 1'b0, 4'd9 },
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd9 },
      '{OP_WR, 3'd2, 8'h10, 8'h00, 1'b0, 1'b0, 4'd12},
      '{OP_WR, 3'd0, 8'h03, 8'h00, 1'b0, 1'b0, 4'd12},
      '{OP_WR, 3'd0, 8'h40, 8'h00, 1'b0, 1'b0, 4'd12},
      '{OP_WR, 3'd2, 8'h01, 8'h00, 1'b0, 1'b0, 4'd12},
      '{OP_RX, 3'd0, 8'hC3, 8'hC3, 1'b1, 1'b1, 4'd12},  // R12 echo out
      '{OP_RD, 3'd1, 8'h00, 8'h0F, 1'b0, 1'b0, 4'd12},
      '{OP_WR, 3'd3, 8'h99, 8'h00, 1'b1, 1'b0, 4'd12},  // R12 host blocked
      '{OP_RD, 3'd1, 8'h00, 8'h0F, 1'b0, 1'b0, 4'd12},  // R12 tx flags kept
      '{OP_WR, 3'd2, 8'h10, 8'h00, 1'b0, 1'b0, 4'd11},
      '{OP_WR, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd11},
      '{OP_WR, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd11},
      '{OP_RD, 3'd3, 8'h00, 8'hC3, 1'b0, 1'b0, 4'd9 },
      '{OP_RX, 3'd0, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd11},
      '{OP_RD, 3'd3, 8'h00, 8'h1F, 1'b0, 1'b0, 4'd11},  // R11 five bits rx
      '{OP_WR, 3'd3, 8'hFF, 8'h1F, 1'b1, 1'b1, 4'd11},  // R11 five bits tx
      '{OP_RD, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, 4'd10},
      '{OP_DN, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 4'd10},
      '{OP_RD, 3'd1, 8'h00, 8'h0C, 1'b0, 1'b0, 4'd10},
      '{OP_WR, 3'd2, 8'h10, 8'h00, 1'b0, 1'b0, 4'd11},
      '{OP_WR, 3'd0, 8'h02, 8'h00, 1'b0, 1'b0, 4'd11},
      '{OP_WR, 3'd3, 8'hFF, 8'h7F, 1'b1, 1'b1, 4'd11}   // R11 seven bits tx
   };

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [IDX_W-1:0] bus_idx = '0;
   logic [7:0]       bus_wdata = '0, rx_byte = '0;
   logic             rx_strobe = 1'b0, tx_done = 1'b0;
   logic [7:0]       bus_rdata, tx_byte;
   logic             tx_start, rx_enabled, tx_enabled;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_chan_regs #(.IDX_W(IDX_W), .ECHO_EN(1'b1)) i_sio_chan_regs (
      .clk        (clk),
      .rst        (rst),
      .bus_sel    (bus_sel),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_idx    (bus_idx),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .rx_strobe  (rx_strobe),
      .rx_byte    (rx_byte),
      .tx_done    (tx_done),
      .tx_start   (tx_start),
      .tx_byte    (tx_byte),
      .rx_enabled (rx_enabled),
      .tx_enabled (tx_enabled)
   );

   task automatic check8(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_step(input vec_t v);
      @(negedge clk);
      bus_sel   = (v.op == OP_RD) || (v.op == OP_WR);
      bus_rd    = (v.op == OP_RD);
      bus_wr    = (v.op == OP_WR);
      bus_idx   = v.idx;
      bus_wdata = v.dat;
      rx_strobe = (v.op == OP_RX);
      rx_byte   = v.dat;
      tx_done   = (v.op == OP_DN);
      #(CLK_PERIOD/4);
      if (v.op == OP_RD) check8("read data", int'(v.req), bus_rdata, v.exp);
      @(posedge clk);
      #(CLK_PERIOD/4);
      bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
      rx_strobe = 1'b0; tx_done = 1'b0;
      if (v.ct) begin
         check8("tx_start", int'(v.req), {7'd0, tx_start}, {7'd0, v.et});
         if (v.et) check8("tx_byte", int'(v.req), tx_byte, v.exp);
      end
   endtask

   function automatic vec_t mk(input logic [1:0] op, input logic [2:0] idx, input logic [7:0] exp, input logic [3:0] req);
      vec_t v;
      v = '{op, idx, 8'h00, exp, 1'b0, 1'b0, req};
      return v;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      rst = 1'b0;
      // R1 outputs right after reset
      check8("rx_enabled after reset", 1, {7'd0, rx_enabled}, 8'h00);
      check8("tx_enabled after reset", 1, {7'd0, tx_enabled}, 8'h00);
      check8("tx_start after reset",   1, {7'd0, tx_start},   8'h00);

      for (int i = 0; i < NV; i++) do_step(VEC[i]);

      // R1 reset in the middle of activity restores pointer and mode values
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      rst = 1'b0;
      check8("tx_start after mid reset", 1, {7'd0, tx_start}, 8'h00);
      check8("tx_enabled after mid reset", 1, {7'd0, tx_enabled}, 8'h00);
      do_step(mk(OP_RD, 3'd1, 8'h00, 4'd1));
      do_step(mk(OP_RD, 3'd0, 8'h03, 4'd1));
      do_step(mk(OP_RD, 3'd0, 8'h00, 4'd1));
      do_step(mk(OP_RD, 3'd7, 8'h00, 4'd13));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule